// File: doc/BRIEF.md
# Row-Scanned LCD Frame Inversion Driver

This block produces the scan sequence for a three-row, four-column passive pixel matrix. A programmable prescaler divides the clock into pixel slots. Each frame holds twelve slots, and each row owns four consecutive slots. During a row's slots one row-select line is high, and the grayscale codes of that row's four pixels appear on a data output one after another. Every code is paired with a polarity bit. The polarity bit holds one value for a whole frame and flips for the next frame, so two frames form one AC drive cycle.

Software or an upstream engine writes pixel codes into a staging buffer at any time. A working copy of that buffer is refreshed only at the start of a frame, so a frame never shows a mix of old and new pixels. A one-clock horizontal pulse marks the last slot of every row. A one-clock vertical pulse marks the last slot of the frame.

Top module: `lcd_row_scan_drv`

## Requirements
- R1: While reset is active, and after reset until the first slot strobe, every row-select output is low, hsync and vsync are low, and the polarity output is 1 (positive).
- R2: From the first slot strobe on, exactly one row-select bit is high. Bit 0 comes first, then bit 1, then bit 2, then back to bit 0. Each bit stays high for 4 slots.
- R3: Within a row, the pixel data output presents pixels at flat index row*4+col in column order 0..3, one pixel per slot.
- R4: The polarity output is 1 during the first frame. It stays constant within a frame and inverts at each frame start.
- R5: hsync is a one-clock pulse. It is high exactly in the strobe cycle that ends column 3 of any row.
- R6: vsync is a one-clock pulse. It is high only together with the hsync of row 2, the last row.
- R7: Codes are 2 bits wide: 00 black, 01 gray, 10 white. The reserved code 11 is output as 10.
- R8: A write lands in the staging buffer and becomes visible only from the next frame start on. A frame start is the first strobe, or the strobe that ends the last slot. Staging and working copies reset to 00.
- R9: A write whose address is 12 or higher changes nothing.
- R10: A slot lasts SLOT_DIV clocks. The first strobe arrives SLOT_DIV clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Staging buffer write enable |
| wr_addr | input | 4 | Pixel index for the write (0..11 valid) |
| wr_data | input | 2 | Grayscale code to write |
| row_sel | output | 3 | One-hot row-select lines |
| pix_data | output | 2 | Grayscale code of the current pixel slot |
| pix_pos | output | 1 | Polarity, 1 = positive |
| hsync | output | 1 | End-of-row pulse |
| vsync | output | 1 | End-of-frame pulse |

## Verification
Counting clock edges m from reset release, the slot state changes at the edge where m is a multiple of SLOT_DIV, starting at m = SLOT_DIV. The sync pulses are high for the one cycle before such an edge, so they are due when m mod SLOT_DIV = SLOT_DIV-1. A write at edge m reaches pix_data only after the next load edge, which falls at m = SLOT_DIV + 48k for SLOT_DIV = 4. The bench advances one edge at a time and computes all five outputs from m and its own shadow model. It samples 1 ns after each edge, when registers and the combinational sync decode have settled.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] gray_t;

  localparam gray_t GRAY_BLACK = 2'b00;
  localparam gray_t GRAY_MID   = 2'b01;
  localparam gray_t GRAY_WHITE = 2'b10;
  localparam gray_t GRAY_RSVD  = 2'b11;

  // Reserved code is shown as white.
  function automatic gray_t gray_clean(gray_t code);
    return (code == GRAY_RSVD) ? GRAY_WHITE : code;
  endfunction

  // Flat pixel number for a row/column pair.
  function automatic int unsigned flat_idx(int unsigned r, int unsigned c,
                                           int unsigned ncols);
    return r * ncols + c;
  endfunction

  // Width of a counter that spans n states, at least 1.
  function automatic int unsigned cnt_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lcd_slot_tick.sv
module lcd_slot_tick
  import lcd_scan_pkg::*;
#(
  parameter int unsigned SLOT_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int unsigned DW = cnt_w(SLOT_DIV);

  generate
    if (SLOT_DIV > 1) begin : g_div
      logic [DW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt == DW'(SLOT_DIV-1)) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign strobe = (cnt == DW'(SLOT_DIV-1));

      // R10: a slot spans more than one clock, so strobes never touch
      a_r10_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    end else begin : g_nodiv
      assign strobe = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/lcd_frame_store.sv
module lcd_frame_store
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NPIX = 12,
  parameter int unsigned AW   = 4,
  parameter int unsigned IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  gray_t         wr_data,
  input  logic          load,
  input  logic [IW-1:0] rd_idx,
  output gray_t         rd_data
);
  localparam int unsigned BW = NPIX * 2;

  logic [BW-1:0] stage;
  logic [BW-1:0] shadow;

  // Staging copy: takes writes at any time; out-of-range addresses drop.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      for (int i = 0; i < NPIX; i++) begin
        if (wr_en && (int'(wr_addr) == i)) stage[i*2 +: 2] <= wr_data;
      end
    end
  end

  // Working copy: refreshed only at a frame start.
  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= stage;
  end

  always_comb begin
    rd_data = GRAY_BLACK;
    for (int i = 0; i < NPIX; i++) begin
      if (int'(rd_idx) == i) rd_data = shadow[i*2 +: 2];
    end
  end

  // R8: the working copy cannot move between frame starts
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow));
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROWS = 3,
  parameter int unsigned COLS = 4,
  parameter int unsigned RW   = 2,
  parameter int unsigned CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  output logic          started,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          pol,
  output logic          row_end,
  output logic          frame_end,
  output logic          frame_load
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS-1);

  assign row_end    = started && (col == COL_LAST);
  assign frame_end  = row_end && (row == ROW_LAST);
  assign frame_load = strobe && (!started || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      row     <= '0;
      col     <= '0;
      pol     <= 1'b1;
    end else if (strobe) begin
      if (!started) begin
        started <= 1'b1;
      end else if (col == COL_LAST) begin
        col <= '0;
        if (row == ROW_LAST) begin
          row <= '0;
          pol <= ~pol;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R4: polarity inverts across every frame boundary
  a_r4_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && frame_end) |=> (pol != $past(pol)));
  // R4: polarity holds everywhere else
  a_r4_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && frame_end) |=> $stable(pol));
  // R2: rows advance by one at a mid-frame row end
  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && row_end && !frame_end) |=> (row == $past(row) + 1'b1));
  // R3: column stays put without a strobe
  a_r3_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(col));
endmodule

// File: rtl/lcd_row_scan_drv.sv
module lcd_row_scan_drv
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROWS     = 3,
  parameter int unsigned COLS     = 4,
  parameter int unsigned SLOT_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [1:0] wr_data,
  output logic [2:0] row_sel,
  output logic [1:0] pix_data,
  output logic       pix_pos,
  output logic       hsync,
  output logic       vsync
);
  localparam int unsigned NPIX = ROWS * COLS;
  localparam int unsigned RW   = cnt_w(ROWS);
  localparam int unsigned CW   = cnt_w(COLS);
  localparam int unsigned IW   = cnt_w(NPIX);

  // Named internal events, visible to the assertions.
  logic          slot_strobe;
  logic          started;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          pol;
  logic          row_end;
  logic          frame_end;
  logic          frame_load;
  logic [IW-1:0] pix_idx;
  gray_t         raw_code;

  lcd_slot_tick #(.SLOT_DIV(SLOT_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (slot_strobe)
  );

  lcd_scan_seq #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (slot_strobe),
    .started    (started),
    .row        (row),
    .col        (col),
    .pol        (pol),
    .row_end    (row_end),
    .frame_end  (frame_end),
    .frame_load (frame_load)
  );

  assign pix_idx = IW'(flat_idx(int'(row), int'(col), COLS));

  lcd_frame_store #(.NPIX(NPIX), .AW(4), .IW(IW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (frame_load),
    .rd_idx  (pix_idx),
    .rd_data (raw_code)
  );

  generate
    for (genvar g = 0; g < ROWS; g++) begin : g_rsel
      assign row_sel[g] = started && (row == RW'(g));
    end
  endgenerate

  assign pix_data = gray_clean(raw_code);
  assign pix_pos  = pol;
  assign hsync    = slot_strobe && row_end;
  assign vsync    = slot_strobe && frame_end;

  // R1: no row driven before scanning begins
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (row_sel == '0 && !hsync && !vsync));
  // R2: exactly one row once scanning
  a_r2_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ($countones(row_sel) == 1));
  // R5: hsync only on a slot strobe, one clock wide
  a_r5_h_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> slot_strobe);
  a_r5_h_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && SLOT_DIV > 1) |=> !hsync);
  // R6: vsync rides on the last row's hsync
  a_r6_v_with_h: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (hsync && row_sel[ROWS-1]));
  // R7: reserved code never reaches the pins
  a_r7_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    pix_data != GRAY_RSVD);
endmodule

// File: tb/sim_lcd_row_scan_drv.sv
`timescale 1ns/1ps
module sim_lcd_row_scan_drv;
  localparam int DIV   = 4;
  localparam int NP    = 12;
  localparam int FRAME = NP * DIV;
  // {addr[3:0], code[1:0]}
  localparam logic [5:0] VEC [12] = '{
    {4'd0, 2'b10}, {4'd1, 2'b01}, {4'd2, 2'b11}, {4'd3, 2'b00},
    {4'd4, 2'b01}, {4'd13, 2'b10}, {4'd5, 2'b10}, {4'd6, 2'b11},
    {4'd7, 2'b01}, {4'd15, 2'b11}, {4'd9, 2'b10}, {4'd11, 2'b01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic [2:0] row_sel;
  logic [1:0] pix_data;
  logic pix_pos, hsync, vsync;

  int total = 0;
  int bad = 0;
  int ncyc = 0;
  int pend [NP];
  int cur [NP];

  always #2.5 clk = ~clk;

  lcd_row_scan_drv #(.ROWS(3), .COLS(4), .SLOT_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .row_sel(row_sel), .pix_data(pix_data),
    .pix_pos(pix_pos), .hsync(hsync), .vsync(vsync)
  );

  function automatic int vis(int c);
    return (c == 3) ? 2 : c;
  endfunction

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, ncyc);
    end
  endtask

  task automatic check_outputs();
    int s, p, strobe;
    if (ncyc < DIV) begin
      check("R1 row_sel idle", int'(row_sel), 0);
      check("R1 pix_pos idle", int'(pix_pos), 1);
      check("R1 hsync idle", int'(hsync), 0);
      check("R1 vsync idle", int'(vsync), 0);
    end else begin
      s = (ncyc - DIV) / DIV;
      p = s % NP;
      strobe = ((ncyc % DIV) == DIV - 1) ? 1 : 0;
      check("R2 row_sel", int'(row_sel), 1 << (p / 4));
      check("R3 R7 R8 R9 pix_data", int'(pix_data), vis(cur[p]));
      check("R4 pix_pos", int'(pix_pos), ((s / NP) % 2 == 0) ? 1 : 0);
      check("R5 R10 hsync", int'(hsync), (strobe == 1 && p % 4 == 3) ? 1 : 0);
      check("R6 vsync", int'(vsync), (strobe == 1 && p == NP - 1) ? 1 : 0);
    end
  endtask

  task automatic step();
    int w, a, d;
    w = int'(wr_en); a = int'(wr_addr); d = int'(wr_data);
    @(posedge clk);
    ncyc++;
    if (ncyc >= DIV && ((ncyc - DIV) % FRAME) == 0)
      for (int i = 0; i < NP; i++) cur[i] = pend[i];
    if (w == 1 && a < NP) pend[a] = d;
    #1;
    check_outputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 row_sel in reset", int'(row_sel), 0);
    check("R1 hsync in reset", int'(hsync), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ncyc = 0;
    for (int i = 0; i < NP; i++) begin pend[i] = 0; cur[i] = 0; end
    #1;
    check_outputs();
  endtask

  task automatic write(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 2'(d);
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // Table walk: writes straddle the first load edge (R8), include
    // reserved code (R7) and out-of-range addresses (R9).
    for (int v = 0; v < 12; v++) write(int'(VEC[v][5:2]), int'(VEC[v][1:0]));
    // Three frames: first frame shows only early writes, then full table.
    while (ncyc < DIV + 3 * FRAME) step();
    // Mid-frame rewrite of every pixel: must wait for the next frame (R8).
    repeat (DIV * 5) step();
    for (int i = 0; i < NP; i++) write(i, (i + 1) % 4);
    write(12, 1);
    write(14, 3);
    while (ncyc < DIV + 6 * FRAME) step();
    // Reset in the middle of a frame, then a short run from the start.
    repeat (DIV * 3) step();
    do_reset();
    while (ncyc < DIV + FRAME + 2 * DIV) step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule